// File: doc/BRIEF.md
# Two-Byte-Per-Clock Table-Driven Pattern Matcher

This block runs a deterministic finite automaton over a byte stream and takes two bytes on every clock. Each byte of the pair first goes through a byte-class table, which maps all 256 byte values onto a small set of class codes. Bytes that always behave the same way, such as both letter cases under a case-blind rule or the members of one range, share a code. Bytes that no rule uses share a single code. The two class codes are then joined and looked up in a pair-class table. This gives a reduced pair class, so the automaton never has to index all 65,536 raw byte pairs. The pair class and the current state select one entry of a dense transition table. That entry holds the next state and an optional match.

A match can end on either byte of a pair. The transition entry says which one, so a pattern that finishes on the leading byte is told apart from one that finishes on the trailing byte. The block reports the rule number, that flag and the absolute byte offset within the stream. A stream with an odd length ends with a lone byte. The block replaces the missing trailing byte with a reserved padding class, and it discards any match that would need that byte.

All three tables are loaded through one write-only configuration port before traffic flows. Lookups are pipelined, so at a fixed clock rate the sustained throughput is twice that of a one-byte-per-clock engine.

Top module: `stride2_dfa_matcher`

## Requirements
- R1: While reset is high and on the first edge after it, `match_valid` is low. The automaton starts in state 0 with pair index 0.
- R2: Each byte is mapped to a class code by a 256-entry byte-class table, written with `cfg_sel`=0 and `cfg_addr[7:0]` = the byte value. Bytes that have the same code produce identical behaviour.
- R3: The pair-class table is indexed by {leading class, trailing class}, with the leading class in the upper CLS_W bits. It yields a PCLS_W-bit pair class and is written with `cfg_sel`=1.
- R4: The transition table is indexed by {state, pair class}, with the state in the upper bits, and is written with `cfg_sel`=2. An entry holds next state in bits [ST_W-1:0], a hit flag at bit ST_W, a trailing-byte flag at bit ST_W+1, and the rule number in the top RULE_W bits.
- R5: One pair is accepted on every clock in which `in_valid` is high. A pair sampled at clock edge k produces its match output on edge k+3.
- R6: `match_off` equals 2 × (pair index since the last `in_sof`) plus the trailing-byte flag. A pair with `in_sof` high is processed from state 0 as pair index 0.
- R7: With `in_lone` high, the trailing byte is replaced by the all-ones padding class. A match flagged as ending on the trailing byte is then dropped, while a leading-byte match is still reported. The byte-class table never yields the padding class.
- R8: A reported match carries the rule number and the trailing-byte flag of the transition entry taken.
- R9: Writing one table through the configuration port leaves the other two tables unchanged.
- R10: A clock with `in_valid` low changes neither the state nor the pair index, and it produces no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 byte-class, 1 pair-class, 2 transition |
| cfg_addr | input | CFG_AW | Table write address |
| cfg_data | input | CFG_DW | Table write data (low bits used) |
| in_valid | input | 1 | Byte pair present |
| in_sof | input | 1 | Pair starts a new stream |
| in_lone | input | 1 | Only the leading byte is real |
| in_byte0 | input | 8 | Leading byte (lower offset) |
| in_byte1 | input | 8 | Trailing byte |
| match_valid | output | 1 | Match reported this cycle |
| match_rule | output | RULE_W | Rule number of the match |
| match_second | output | 1 | Match ended on the trailing byte |
| match_off | output | OFF_W | Byte offset of the final matching byte |

## Verification
The bench goes after lone-byte pairs whose table entry flags a trailing-byte hit. A design that ignored the padding rule would report a match at an offset past the end of the stream. It also restarts streams in the middle of traffic with `in_sof`. A block that kept its old state or pair index would then report wrong offsets and follow wrong transitions. Gaps with `in_valid` low are mixed into bursts, which exposes a design that advances its state or offset on idle cycles. Random tables in which many classes share pair classes catch a wrong index ordering in either table, because the leading and trailing lanes would then be swapped.

// File: rtl/s2dfa_pkg.sv
package s2dfa_pkg;
  typedef enum logic [1:0] {
    TBL_BYTE  = 2'd0,
    TBL_PAIR  = 2'd1,
    TBL_TRANS = 2'd2
  } tbl_sel_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/s2dfa_byte_class.sv
module s2dfa_byte_class #(
  parameter int CLS_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [7:0]       waddr,
  input  logic [CLS_W-1:0] wdata,
  input  logic [7:0]       byte0,
  input  logic [7:0]       byte1,
  output logic [CLS_W-1:0] cls0,
  output logic [CLS_W-1:0] cls1
);
  localparam int DEPTH = 256;

  logic [7:0]       lane_addr [2];
  logic [CLS_W-1:0] lane_q    [2];

  assign lane_addr[0] = byte0;
  assign lane_addr[1] = byte1;

  // One copy of the table per lane keeps each RAM to one write and one read port.
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [CLS_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      lane_q[l] <= mem[lane_addr[l]];
    end
  end

  assign cls0 = lane_q[0];
  assign cls1 = lane_q[1];
endmodule

// File: rtl/s2dfa_pair_class.sv
module s2dfa_pair_class #(
  parameter int CLS_W  = 6,
  parameter int PCLS_W = 9
) (
  input  logic               clk,
  input  logic               we,
  input  logic [2*CLS_W-1:0] waddr,
  input  logic [PCLS_W-1:0]  wdata,
  input  logic [CLS_W-1:0]   cls0,
  input  logic [CLS_W-1:0]   cls1,
  input  logic               lone,
  output logic [PCLS_W-1:0]  pcls
);
  localparam int DEPTH = 1 << (2 * CLS_W);
  localparam logic [CLS_W-1:0] PAD_CLS = '1;

  logic [PCLS_W-1:0]  mem [DEPTH];
  logic [CLS_W-1:0]   trail;
  logic [2*CLS_W-1:0] raddr;

  // A missing trailing byte is looked up as the reserved padding class.
  assign trail = lone ? PAD_CLS : cls1;
  assign raddr = {cls0, trail};

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    pcls <= mem[raddr];
  end
endmodule

// File: rtl/s2dfa_trans_rows.sv
module s2dfa_trans_rows #(
  parameter int ST_W   = 3,
  parameter int PCLS_W = 9,
  parameter int ENT_W  = 9
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [ST_W+PCLS_W-1:0]         waddr,
  input  logic [ENT_W-1:0]               wdata,
  input  logic [PCLS_W-1:0]              pcls,
  output logic [(1<<ST_W)*ENT_W-1:0]     row
);
  localparam int NST   = 1 << ST_W;
  localparam int DEPTH = 1 << PCLS_W;

  logic [ST_W-1:0]   w_state;
  logic [PCLS_W-1:0] w_pcls;

  assign w_state = waddr[ST_W+PCLS_W-1:PCLS_W];
  assign w_pcls  = waddr[PCLS_W-1:0];

  // One bank per current state: all candidates are read ahead of knowing
  // the state, so the state loop closes through a mux only.
  for (genvar s = 0; s < NST; s++) begin : g_bank
    logic [ENT_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (w_state == ST_W'(s))) mem[w_pcls] <= wdata;
      row[s*ENT_W +: ENT_W] <= mem[pcls];
    end
  end
endmodule

// File: rtl/stride2_dfa_matcher.sv
module stride2_dfa_matcher
  import s2dfa_pkg::*;
#(
  parameter int CLS_W  = 6,
  parameter int PCLS_W = 9,
  parameter int ST_W   = 3,
  parameter int RULE_W = 4,
  parameter int OFF_W  = 16,
  parameter int CFG_AW = imax(imax(8, 2 * CLS_W), ST_W + PCLS_W),
  parameter int CFG_DW = imax(imax(CLS_W, PCLS_W), ST_W + 2 + RULE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_lone,
  input  logic [7:0]        in_byte0,
  input  logic [7:0]        in_byte1,
  output logic              match_valid,
  output logic [RULE_W-1:0] match_rule,
  output logic              match_second,
  output logic [OFF_W-1:0]  match_off
);
  localparam int ENT_W = ST_W + 2 + RULE_W;
  localparam int NST   = 1 << ST_W;
  localparam int HIT_B = ST_W;
  localparam int SEC_B = ST_W + 1;
  localparam int IDX_W = OFF_W - 1;
  localparam logic [CLS_W-1:0] PAD_CLS = '1;

  logic we_byte, we_pair, we_trans;
  assign we_byte  = cfg_we && (tbl_sel_e'(cfg_sel) == TBL_BYTE);
  assign we_pair  = cfg_we && (tbl_sel_e'(cfg_sel) == TBL_PAIR);
  assign we_trans = cfg_we && (tbl_sel_e'(cfg_sel) == TBL_TRANS);

  // Stage A: byte classes
  logic [CLS_W-1:0] cls0_a, cls1_a;
  logic v_a, sof_a, lone_a;

  s2dfa_byte_class #(.CLS_W(CLS_W)) u_bytes (
    .clk  (clk),
    .we   (we_byte),
    .waddr(cfg_addr[7:0]),
    .wdata(cfg_data[CLS_W-1:0]),
    .byte0(in_byte0),
    .byte1(in_byte1),
    .cls0 (cls0_a),
    .cls1 (cls1_a)
  );

  // Stage B: pair class
  logic [PCLS_W-1:0] pcls_b;
  logic v_b, sof_b, lone_b;

  s2dfa_pair_class #(.CLS_W(CLS_W), .PCLS_W(PCLS_W)) u_pairs (
    .clk  (clk),
    .we   (we_pair),
    .waddr(cfg_addr[2*CLS_W-1:0]),
    .wdata(cfg_data[PCLS_W-1:0]),
    .cls0 (cls0_a),
    .cls1 (cls1_a),
    .lone (lone_a),
    .pcls (pcls_b)
  );

  // Stage C: candidate entries for every state
  logic [NST*ENT_W-1:0] row_c;
  logic v_c, sof_c, lone_c;

  s2dfa_trans_rows #(.ST_W(ST_W), .PCLS_W(PCLS_W), .ENT_W(ENT_W)) u_rows (
    .clk  (clk),
    .we   (we_trans),
    .waddr(cfg_addr[ST_W+PCLS_W-1:0]),
    .wdata(cfg_data[ENT_W-1:0]),
    .pcls (pcls_b),
    .row  (row_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_a <= 1'b0; v_b <= 1'b0; v_c <= 1'b0;
    end else begin
      v_a <= in_valid; v_b <= v_a; v_c <= v_b;
    end
    sof_a  <= in_sof;  sof_b  <= sof_a;  sof_c  <= sof_b;
    lone_a <= in_lone; lone_b <= lone_a; lone_c <= lone_b;
  end

  // Stage D: state loop and match register
  logic [ST_W-1:0]  state_q, cur_st;
  logic [IDX_W-1:0] pair_q, cur_idx;
  logic [ENT_W-1:0] ent;
  logic             ent_hit, ent_sec;

  assign cur_st  = sof_c ? '0 : state_q;
  assign cur_idx = sof_c ? '0 : pair_q;
  assign ent     = row_c[int'(cur_st)*ENT_W +: ENT_W];
  assign ent_hit = ent[HIT_B];
  assign ent_sec = ent[SEC_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= '0;
      pair_q       <= '0;
      match_valid  <= 1'b0;
      match_rule   <= '0;
      match_second <= 1'b0;
      match_off    <= '0;
    end else begin
      match_valid <= 1'b0;
      if (v_c) begin
        state_q      <= ent[ST_W-1:0];
        pair_q       <= cur_idx + 1'b1;
        match_valid  <= ent_hit && !(lone_c && ent_sec);
        match_rule   <= ent[ENT_W-1 -: RULE_W];
        match_second <= ent_sec;
        match_off    <= {cur_idx, ent_sec};
      end
    end
  end

  // ---------------- assertions ----------------
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !match_valid);

  a_r5_match_latency: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> $past(in_valid, 4));

  a_r7_pad_blocks_trailing: assert property (@(posedge clk) disable iff (rst)
    (match_valid && match_second) |-> !$past(in_lone, 4));

  a_r7_table_pad_free: assert property (@(posedge clk) disable iff (rst)
    v_a |-> (cls0_a != PAD_CLS && cls1_a != PAD_CLS));

  a_r6_offset_step: assert property (@(posedge clk) disable iff (rst)
    (match_valid && $past(match_valid) && !$past(in_sof, 4)) |->
      (match_off[OFF_W-1:1] == IDX_W'($past(match_off[OFF_W-1:1]) + 1'b1)));

  a_r10_idle_holds_state: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid, 4) |-> $stable(state_q));
endmodule

// File: tb/stride2_dfa_matcher_tb.sv
module stride2_dfa_matcher_tb_top;
  localparam int CLS_W  = 6;
  localparam int PCLS_W = 9;
  localparam int ST_W   = 3;
  localparam int RULE_W = 4;
  localparam int OFF_W  = 16;
  localparam int CFG_AW = 12;
  localparam int CFG_DW = 9;
  localparam int NST    = 1 << ST_W;
  localparam int NPC    = 1 << PCLS_W;
  localparam int NPAIR  = 1 << (2 * CLS_W);
  localparam int PAD    = (1 << CLS_W) - 1;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we;
  logic [1:0] cfg_sel;
  logic [CFG_AW-1:0] cfg_addr;
  logic [CFG_DW-1:0] cfg_data;
  logic in_valid, in_sof, in_lone;
  logic [7:0] in_byte0, in_byte1;
  logic match_valid, match_second;
  logic [RULE_W-1:0] match_rule;
  logic [OFF_W-1:0] match_off;

  always #5 clk = ~clk;

  stride2_dfa_matcher dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_sof(in_sof), .in_lone(in_lone), .in_byte0(in_byte0),
    .in_byte1(in_byte1), .match_valid(match_valid), .match_rule(match_rule),
    .match_second(match_second), .match_off(match_off)
  );

  int checks = 0;
  int errors = 0;

  // reference tables
  int bt [256];
  int pt [NPAIR];
  int tt [NST][NPC];   // {rule, sec, hit, next}
  int m_state = 0;
  int m_idx = 0;

  // expected output pipeline, slot 3 is due at the current sample point
  logic       e_v   [4];
  int         e_rule[4];
  logic       e_sec [4];
  int         e_off [4];
  string      e_tag [4];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9: one table per write, selected by cfg_sel
  task automatic cfg_write(input int sel, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel);
    cfg_addr = CFG_AW'(addr); cfg_data = CFG_DW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic shift_expect();
    for (int i = 3; i > 0; i--) begin
      e_v[i] = e_v[i-1]; e_rule[i] = e_rule[i-1];
      e_sec[i] = e_sec[i-1]; e_off[i] = e_off[i-1]; e_tag[i] = e_tag[i-1];
    end
  endtask

  task automatic check_due();
    check({e_tag[3], " match_valid"}, int'(match_valid), int'(e_v[3]));
    if (e_v[3] && match_valid) begin
      check("R8 match_rule", int'(match_rule), e_rule[3]);
      check("R8 match_second", int'(match_second), int'(e_sec[3]));
      check("R6 match_off", int'(match_off), e_off[3]);
    end
  endtask

  // one clock of traffic; the reference model is advanced in step
  task automatic step(input logic v, input logic sof, input logic lone,
                      input int b0, input int b1);
    int c0, c1, pc, ent, hit, sec;
    @(negedge clk);
    check_due();
    shift_expect();
    in_valid = v; in_sof = sof; in_lone = lone;
    in_byte0 = 8'(b0); in_byte1 = 8'(b1);
    e_v[0] = 1'b0; e_rule[0] = 0; e_sec[0] = 1'b0; e_off[0] = 0;
    e_tag[0] = v ? "R5" : "R10";
    if (v) begin
      if (sof) begin m_state = 0; m_idx = 0; end
      c0 = bt[b0];                       // R2 byte classes
      c1 = lone ? PAD : bt[b1];          // R7 padding class
      pc = pt[(c0 << CLS_W) | c1];       // R3 pair index ordering
      ent = tt[m_state][pc];             // R4 entry layout
      hit = (ent >> ST_W) & 1;
      sec = (ent >> (ST_W + 1)) & 1;
      if (lone && sec == 1) e_tag[0] = "R7";
      e_v[0]   = (hit == 1) && !(lone && sec == 1);
      e_rule[0] = ent >> (ST_W + 2);
      e_sec[0]  = sec[0];
      e_off[0]  = ((2 * m_idx) + sec) & ((1 << OFF_W) - 1);
      m_state = ent & (NST - 1);
      m_idx   = (m_idx + 1) & ((1 << (OFF_W - 1)) - 1);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_addr = '0; cfg_data = '0;
    in_valid = 1'b0; in_sof = 1'b0; in_lone = 1'b0; in_byte0 = '0; in_byte1 = '0;
    for (int i = 0; i < 4; i++) begin
      e_v[i] = 1'b0; e_rule[i] = 0; e_sec[i] = 1'b0; e_off[i] = 0; e_tag[i] = "R1";
    end
    repeat (3) @(negedge clk);
    check("R1 match_valid in reset", int'(match_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 match_valid after reset", int'(match_valid), 0);

    // program tables; classes drawn from a small range so bytes alias (R2)
    for (int b = 0; b < 256; b++) begin
      bt[b] = $urandom_range(0, 11);
      if (b >= 8'h41 && b <= 8'h5A) bt[b] = 5;   // a shared range class
      cfg_write(0, b, bt[b]);
    end
    for (int p = 0; p < NPAIR; p++) begin
      pt[p] = $urandom_range(0, NPC - 1);
      cfg_write(1, p, pt[p]);
    end
    // R9: rewrite the byte table entries for lane checks later? keep as is;
    // transition writes below must not disturb pt/bt (checked by the stream)
    for (int s = 0; s < NST; s++) begin
      for (int p = 0; p < NPC; p++) begin
        int hit = ($urandom_range(0, 2) == 0) ? 1 : 0;
        tt[s][p] = ($urandom_range(0, (1 << RULE_W) - 1) << (ST_W + 2)) |
                   ($urandom_range(0, 1) << (ST_W + 1)) |
                   (hit << ST_W) | $urandom_range(0, NST - 1);
        cfg_write(2, (s << PCLS_W) | p, tt[s][p]);
      end
    end

    // directed: lone first pair of a stream, then a back-to-back burst
    step(1'b1, 1'b1, 1'b1, 8'h41, 8'h00);
    for (int i = 0; i < 40; i++)
      step(1'b1, i == 0, 1'b0, $urandom_range(0, 255), $urandom_range(0, 255));
    // directed: idle gap, then a restart mid-stream (R6, R10)
    step(1'b0, 1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b0, 1'b0, 0, 0);
    step(1'b1, 1'b1, 1'b0, 8'h5A, 8'h61);
    // directed: case aliasing in the shared range must behave alike (R2)
    step(1'b1, 1'b0, 1'b0, 8'h42, 8'h43);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic v    = ($urandom_range(0, 7) != 0);
      logic sof  = ($urandom_range(0, 31) == 0);
      logic lone = ($urandom_range(0, 3) == 0);
      step(v, sof, lone, $urandom_range(0, 255), $urandom_range(0, 255));
    end
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule